// File: doc/BRIEF.md
# Key Event Queue with Repeat Reads

This block holds decoded keypad events in a 16-slot circular store until a register interface hands them to software. Each event comes in as a 7-bit key code and a press/release flag, and is stored as one byte with the flag in bit 7. Scanning and debouncing happen upstream, so events arrive already decoded.

There are two read paths. A consuming read moves past one event and hands back the slot it lands on. A repeat read returns the byte at an index relative to the current start slot and changes no state. After a consuming read, the start slot still holds the event that was just consumed. A repeat read at index 0 therefore shows the previously serviced event.

The surrounding register logic owns the interrupt and error bits. This block supplies a strobe when an event is accepted, a strobe when an event is lost because the queue is full, and its current fill count. The register logic feeds back the error-status and overflow-flag levels, which mute further events without raising a new error. It also sends a flush strobe when the configuration is rewritten.

Top module: `kev_fifo`

## Requirements
- R1: After reset, `fill_len` is 0, `key_irq` and `ovf_drop` are low, and both read outputs are 0.
- R2: An accepted push writes the byte {pressed, code[6:0]} (flag in bit 7) into slot (start + length) mod 16 and raises `fill_len` by one at the next edge.
- R3: `key_irq` is high in exactly those cycles in which a push is accepted.
- R4: A push that meets a length of 16 is not stored, leaves the length at 16 and raises `ovf_drop` for that cycle.
- R5: While `err_status` and `ovf_err` are both high, a push is discarded with neither `key_irq` nor `ovf_drop`, and nothing is stored.
- R6: `pop_data` is 0 when the length is 1 or less, and a `pop_req` then changes nothing. Otherwise `pop_data` is the byte at (start + 1) mod 16, and a `pop_req` advances start by one and lowers the length by one.
- R7: `peek_data` is 0 when `peek_idx` is at least the length. Otherwise it is the byte at (start + `peek_idx`) mod 16. Repeat reads never change state, so index 0 shows the most recently consumed event.
- R8: `flush` clears start and length to 0 and overrides a `pop_req` in the same cycle. A push in the same cycle is then stored in slot 0, leaving the length at 1.
- R9: When a push and a consuming read occur in the same cycle, the read is applied first. A push to a full queue is then accepted if the read frees a slot.
- R10: All slot arithmetic wraps modulo 16, so writes and reads continue correctly across the end of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear start and length |
| push_valid | input | 1 | New key event this cycle |
| push_code | input | 7 | Key code of the event |
| push_pressed | input | 1 | 1 = press, 0 = release |
| err_status | input | 1 | Error-status level from the register logic |
| ovf_err | input | 1 | Overflow-flag level from the register logic |
| pop_req | input | 1 | Consuming read this cycle |
| pop_data | output | 8 | Byte a consuming read returns this cycle |
| peek_idx | input | 8 | Byte index of the repeat read |
| peek_data | output | 8 | Byte the repeat read returns |
| fill_len | output | 5 | Current number of counted events |
| key_irq | output | 1 | Push accepted this cycle |
| ovf_drop | output | 1 | Push lost to a full queue this cycle |

## Verification
The assertions treat `flush`, `pop_req` and `push_valid` as strobes sampled once per clock. They treat the error-level inputs as arbitrary levels that need not agree with the block's own history, and `peek_idx` as any 8-bit value, including indices far past the length. The stimulus changes every input only at the falling edge and starts with reset held for several cycles. A free-running phase mixes pushes, consuming reads and rare flushes with the error levels toggled at random, so the store fills, wraps, overflows and drains many times.

// File: rtl/kev_pkg.sv
package kev_pkg;

    localparam int KEV_DEPTH  = 16;
    localparam int KEV_CODE_W = 7;
    localparam int KEV_IDX_W  = 8;

    typedef struct packed {
        logic                  pressed;
        logic [KEV_CODE_W-1:0] code;
    } kev_event_t;

    localparam int KEV_EVT_W = $bits(kev_event_t);

    typedef enum logic [1:0] {
        PUSH_NONE  = 2'd0,
        PUSH_STORE = 2'd1,
        PUSH_FULL  = 2'd2,
        PUSH_MUTED = 2'd3
    } push_fate_e;

    // Muting has priority over the full check: a muted event never raises a new error.
    function automatic push_fate_e classify_push(input logic req, input logic muted,
                                                 input logic full);
        if (!req)
            return PUSH_NONE;
        else if (muted)
            return PUSH_MUTED;
        else if (full)
            return PUSH_FULL;
        else
            return PUSH_STORE;
    endfunction

    function automatic kev_event_t make_event(input logic [KEV_CODE_W-1:0] code,
                                              input logic pressed);
        kev_event_t e;
        e.pressed = pressed;
        e.code    = code;
        return e;
    endfunction

endpackage

// File: rtl/kev_ptr_ctrl.sv
module kev_ptr_ctrl
    import kev_pkg::*;
#(
    parameter  int DEPTH = KEV_DEPTH,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             pop_req,
    input  logic             push_req,
    input  logic             muted,
    output logic [PTR_W-1:0] start_q,
    output logic [LEN_W-1:0] len_q,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_slot,
    output logic             key_irq,
    output logic             ovf_drop
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    logic [PTR_W-1:0] s_flushed, s_popped;
    logic [LEN_W-1:0] l_flushed, l_popped, l_next;
    logic             pop_ok;
    push_fate_e       fate;

    // Order within a cycle: flush, then consuming read, then push.
    always_comb begin
        s_flushed = flush ? '0 : start_q;
        l_flushed = flush ? '0 : len_q;
        pop_ok    = pop_req && (l_flushed > LEN_ONE);
        s_popped  = pop_ok ? s_flushed + PTR_ONE : s_flushed;
        l_popped  = pop_ok ? l_flushed - LEN_ONE : l_flushed;
        fate      = classify_push(push_req, muted, l_popped == FULL_LEN);
        wr_en     = (fate == PUSH_STORE);
        wr_slot   = s_popped + l_popped[PTR_W-1:0];
        l_next    = wr_en ? l_popped + LEN_ONE : l_popped;
        key_irq   = wr_en;
        ovf_drop  = (fate == PUSH_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            len_q   <= '0;
        end else begin
            start_q <= s_popped;
            len_q   <= l_next;
        end
    end

    p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
        len_q <= FULL_LEN);

    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (key_irq && !pop_req && !flush) |=> (len_q == $past(len_q) + LEN_ONE));

    p_irq_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(key_irq && ovf_drop));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_drop |=> (len_q == FULL_LEN));

    p_muted_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (push_req && muted) |-> (!key_irq && !ovf_drop));

    p_short_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !flush && len_q <= LEN_ONE)
            |=> ($stable(len_q) && $stable(start_q)));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!pop_req && !push_req && !flush) |=> ($stable(len_q) && $stable(start_q)));

    p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (flush && !push_req) |=> (len_q == '0 && start_q == '0));

    p_pop_then_push_r9: assert property (@(posedge clk) disable iff (rst)
        (pop_req && push_req && !muted && !flush && len_q == FULL_LEN) |-> key_irq);

endmodule

// File: rtl/kev_store.sv
module kev_store
    import kev_pkg::*;
#(
    parameter  int DEPTH = KEV_DEPTH,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_slot,
    input  kev_event_t             wr_data,
    output kev_event_t [DEPTH-1:0] slots
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[g] <= '0;
            else if (wr_en && (wr_slot == PTR_W'(g)))
                slots[g] <= wr_data;
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (slots[$past(wr_slot)] == $past(wr_data)));

endmodule

// File: rtl/kev_read_mux.sv
module kev_read_mux
    import kev_pkg::*;
#(
    parameter  int DEPTH = KEV_DEPTH,
    parameter  int IDX_W = KEV_IDX_W,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  kev_event_t [DEPTH-1:0] slots,
    input  logic [PTR_W-1:0]       start_q,
    input  logic [LEN_W-1:0]       len_q,
    input  logic [IDX_W-1:0]       peek_idx,
    output kev_event_t             pop_data,
    output kev_event_t             peek_data
);

    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic [PTR_W-1:0] pop_slot, peek_slot;
    logic             peek_hit;

    always_comb begin
        pop_slot  = start_q + PTR_ONE;
        peek_slot = start_q + peek_idx[PTR_W-1:0];
        peek_hit  = int'(peek_idx) < int'(len_q);
        pop_data  = (len_q > LEN_ONE) ? slots[pop_slot] : '0;
        peek_data = peek_hit ? slots[peek_slot] : '0;
    end

endmodule

// File: rtl/kev_fifo.sv
module kev_fifo
    import kev_pkg::*;
#(
    parameter  int DEPTH  = KEV_DEPTH,
    parameter  int IDX_W  = KEV_IDX_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LEN_W  = PTR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  push_valid,
    input  logic [KEV_CODE_W-1:0] push_code,
    input  logic                  push_pressed,
    input  logic                  err_status,
    input  logic                  ovf_err,
    input  logic                  pop_req,
    output logic [KEV_EVT_W-1:0]  pop_data,
    input  logic [IDX_W-1:0]      peek_idx,
    output logic [KEV_EVT_W-1:0]  peek_data,
    output logic [LEN_W-1:0]      fill_len,
    output logic                  key_irq,
    output logic                  ovf_drop
);

    logic [PTR_W-1:0]       start_q, wr_slot;
    logic [LEN_W-1:0]       len_q;
    logic                   wr_en;
    kev_event_t             wr_data;
    kev_event_t [DEPTH-1:0] slots;
    kev_event_t             pop_evt, peek_evt;

    assign wr_data = make_event(push_code, push_pressed);

    kev_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .pop_req  (pop_req),
        .push_req (push_valid),
        .muted    (err_status && ovf_err),
        .start_q  (start_q),
        .len_q    (len_q),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .key_irq  (key_irq),
        .ovf_drop (ovf_drop)
    );

    kev_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .slots   (slots)
    );

    kev_read_mux #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_rd (
        .slots     (slots),
        .start_q   (start_q),
        .len_q     (len_q),
        .peek_idx  (peek_idx),
        .pop_data  (pop_evt),
        .peek_data (peek_evt)
    );

    assign pop_data  = pop_evt;
    assign peek_data = peek_evt;
    assign fill_len  = len_q;

    p_pop_head_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !flush && !push_valid && len_q > LEN_W'(1))
            |=> (peek_idx != '0 || peek_data == $past(pop_data)));

    p_far_peek_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(peek_idx) >= DEPTH) |-> (peek_data == '0));

endmodule

// File: tb/test_kev_fifo.sv
`timescale 1ns/1ps
module test_kev_fifo;

    logic       clk = 1'b0;
    logic       rst;
    logic       flush, push_valid, push_pressed, err_status, ovf_err, pop_req;
    logic [6:0] push_code;
    logic [7:0] peek_idx;
    logic [7:0] pop_data, peek_data;
    logic [4:0] fill_len;
    logic       key_irq, ovf_drop;

    always #2 clk = ~clk;

    kev_fifo i_kev_fifo (
        .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid),
        .push_code(push_code), .push_pressed(push_pressed),
        .err_status(err_status), .ovf_err(ovf_err), .pop_req(pop_req),
        .pop_data(pop_data), .peek_idx(peek_idx), .peek_data(peek_data),
        .fill_len(fill_len), .key_irq(key_irq), .ovf_drop(ovf_drop)
    );

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    // reference model
    logic [7:0] m_mem [16];
    int         m_start = 0;
    int         m_len   = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at falling edge, check combinational outputs, advance model at rising edge.
    task automatic step(input string tag, input bit fl, input bit pu, input logic [6:0] code,
                        input bit pr, input bit po, input logic [7:0] idx,
                        input bit er, input bit ov);
        int s1, l1, s2, l2;
        bit acc, full_drop;
        int exp_pop, exp_peek;
        flush = fl; push_valid = pu; push_code = code; push_pressed = pr;
        pop_req = po; peek_idx = idx; err_status = er; ovf_err = ov;
        #1;
        s1 = fl ? 0 : m_start;
        l1 = fl ? 0 : m_len;
        if (po && l1 > 1) begin s2 = (s1 + 1) % 16; l2 = l1 - 1; end
        else begin s2 = s1; l2 = l1; end
        acc       = pu && !(er && ov) && (l2 < 16);
        full_drop = pu && !(er && ov) && (l2 >= 16);
        exp_pop   = (m_len > 1) ? int'(m_mem[(m_start + 1) % 16]) : 0;
        exp_peek  = (int'(idx) < m_len) ? int'(m_mem[(m_start + int'(idx)) % 16]) : 0;
        chk({tag, "/R2"}, "fill_len", int'(fill_len), m_len);
        chk({tag, "/R6"}, "pop_data", int'(pop_data), exp_pop);
        chk({tag, "/R7"}, "peek_data", int'(peek_data), exp_peek);
        chk({tag, "/R3"}, "key_irq", int'(key_irq), int'(acc));
        chk({tag, "/R4"}, "ovf_drop", int'(ovf_drop), int'(full_drop));
        @(posedge clk);
        if (acc) begin
            m_mem[(s2 + l2) % 16] = {pr, code};
            l2++;
        end
        m_start = s2;
        m_len   = l2;
        @(negedge clk);
    endtask

    task automatic idle_peek(input string tag, input logic [7:0] idx);
        step(tag, 0, 0, 7'h0, 0, 0, idx, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
        rst = 1; flush = 0; push_valid = 0; push_code = 0; push_pressed = 0;
        err_status = 0; ovf_err = 0; pop_req = 0; peek_idx = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        #1;
        chk("R1", "fill_len", int'(fill_len), 0);
        chk("R1", "pop_data", int'(pop_data), 0);
        chk("R1", "peek_data", int'(peek_data), 0);
        chk("R1", "key_irq", int'(key_irq), 0);
        chk("R1", "ovf_drop", int'(ovf_drop), 0);
        @(negedge clk);

        // R2: pushes with press/release flag in bit 7
        step("R2", 0, 1, 7'h55, 0, 0, 0, 0, 0);
        step("R2", 0, 1, 7'h3c, 1, 0, 0, 0, 0);
        step("R2", 0, 1, 7'h12, 0, 0, 0, 0, 0);
        idle_peek("R2", 8'd1);
        chk("R2", "event byte", int'(peek_data), 8'hbc);
        for (int i = 0; i < 4; i++) idle_peek("R7", 8'(i));

        // R6/R7: consuming read, then peek 0 shows consumed event
        step("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        idle_peek("R7", 8'd0);
        chk("R7", "peek0 after pop", int'(peek_data), 8'hbc);
        step("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        idle_peek("R6", 8'd0);
        chk("R6", "len after short pop", int'(fill_len), 1);
        chk("R6", "pop_data at len1", int'(pop_data), 0);

        // R10/R4: fill across the wrap point, then overflow
        for (int i = 0; i < 16; i++) step("R10", 0, 1, 7'(8'h20 + i), i[0], 0, 8'(i), 0, 0);
        idle_peek("R10", 8'd15);
        chk("R10", "len full", int'(fill_len), 16);
        step("R4", 0, 1, 7'h7f, 1, 0, 8'd15, 0, 0);
        idle_peek("R4", 8'd15);
        chk("R4", "len after drop", int'(fill_len), 16);

        // R5: muted drop
        step("R5", 0, 1, 7'h01, 0, 0, 0, 1, 1);
        step("R5", 0, 1, 7'h01, 0, 0, 0, 1, 0);

        // R9: pop + push at full
        step("R9", 0, 1, 7'h44, 1, 1, 8'd15, 0, 0);
        idle_peek("R9", 8'd15);
        chk("R9", "len after pop+push", int'(fill_len), 16);
        chk("R9", "newest entry", int'(peek_data), 8'hc4);

        // R8: flush with push lands in slot 0
        step("R8", 1, 1, 7'h0a, 1, 1, 0, 0, 0);
        idle_peek("R8", 8'd0);
        chk("R8", "len after flush", int'(fill_len), 1);
        chk("R8", "slot0 after flush", int'(peek_data), 8'h8a);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 0);
        idle_peek("R8", 8'd0);
        chk("R8", "len after bare flush", int'(fill_len), 0);

        // mixed traffic
        for (int c = 0; c < 3000; c++) begin
            int r = $urandom_range(0, 99);
            step("R10", ($urandom_range(0, 63) == 0), (r < 60), 7'($urandom),
                 1'($urandom), ($urandom_range(0, 99) < 45), 8'($urandom_range(0, 20)),
                 ($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 3));
        end

        finish_run();
    end

endmodule